// File: doc/BRIEF.md
# Burst address sequencer

This block drives the address phase of a pipelined on-chip bus on behalf of a master. A command carries a start address, a transfer size code, a burst code and a write flag. Once the command is taken, the block puts out one address phase per beat: the beat address, a transfer-type code, and the size, burst and direction of the burst. The bus stalls the block by pulling `bus_ready` low. While it is low, every output holds.

For each beat the block computes the following address. An incrementing burst adds the beat size. A wrapping burst folds the address back inside an aligned block whose size is the beat count times the beat size. The user can put idle-but-owned (BUSY) cycles between beats with `stall`. `abort` ends the current burst after the beat on the bus, and it is also the normal way to end an undefined-length incrementing burst. A new command can be taken in the same cycle as the final beat, so consecutive bursts follow each other with no gap.

The controller has three states:
- ST_IDLE drives IDLE.
- ST_BEAT drives a NONSEQ or SEQ beat.
- ST_BUSY drives BUSY.

The transitions, all taken only while `bus_ready` is high, are:
- take: from any state, a command is accepted and the next state is ST_BEAT.
- finish: from ST_BEAT, on the final beat or on abort, the next state is ST_IDLE.
- pause: from ST_BEAT, with stall set and a beat left, the next state is ST_BUSY.
- advance: from ST_BEAT, the next state is ST_BEAT for the following beat.
- resume: from ST_BUSY, with stall clear, the next state is ST_BEAT.
- linger: from ST_BUSY, with stall set, the state stays ST_BUSY.
- drop: from ST_BUSY, on abort, the next state is ST_IDLE.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset `bus_trans` is IDLE (2'b00). While the block shows IDLE, `cmd_ready` equals `bus_ready`.
- R2: A command taken at a clock edge (`cmd_valid` and `cmd_ready` both high) is shown from that edge on. `bus_trans` is NONSEQ (2'b10), `bus_addr` is the start address, and `bus_size`, `bus_burst` and `bus_write` carry the command's fields.
- R3: The burst code sets the beat count: 3'b000 single = 1 beat, 3'b011/3'b010 incr/wrap = 4, 3'b101/3'b100 = 8, 3'b111/3'b110 = 16. After the final beat is accepted, `bus_trans` returns to IDLE unless a new command is taken. A single burst never shows SEQ or BUSY.
- R4: In an incrementing burst each beat address is the previous one plus 2^size bytes, with size code 0..4 giving 1, 2, 4, 8 or 16 bytes. The sum rolls over modulo 2^ADDR_W.
- R5: In a wrapping burst the block is beats×2^size bytes, aligned, and contains the start address. Only the address bits below the block size change, and stepping past the top returns to the block's base.
- R6: Every beat after the first shows SEQ (2'b11).
- R7: While `bus_ready` is low, `bus_addr`, `bus_trans`, `bus_size`, `bus_burst` and `bus_write` hold their values.
- R8: `stall` with a beat still to come gives BUSY (2'b01) showing the next beat's address. That address and the beat count hold for as long as BUSY lasts, and SEQ follows at the same address when `stall` clears. `stall` on the final beat or on a single burst is ignored.
- R9: `abort` accepted with `bus_ready` ends the burst: the next cycle is IDLE, or NONSEQ if a command is taken. An undefined-length incrementing burst (3'b001) runs until it is aborted.
- R10: `cmd_ready` is high during the accepted final beat of a burst, so a command taken there is shown as NONSEQ in the very next cycle, with no IDLE between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The offered command is taken at this edge |
| cmd_addr | input | ADDR_W | Start address, aligned to the size |
| cmd_size | input | 3 | Size code, 0..MAX_SIZE |
| cmd_burst | input | 3 | Burst code |
| cmd_write | input | 1 | 1 = write burst |
| stall | input | 1 | Request a BUSY cycle before the next beat |
| abort | input | 1 | End the burst after the current beat |
| bus_ready | input | 1 | The current address phase is accepted |
| bus_addr | output | ADDR_W | Beat address |
| bus_trans | output | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| bus_size | output | 3 | Size code of the burst |
| bus_burst | output | 3 | Burst code of the burst |
| bus_write | output | 1 | Direction of the burst |

## Verification
The assertions assume the following about the inputs:
- Start addresses are aligned to the size.
- Size codes never exceed MAX_SIZE.
- Commands are offered only when they can be taken or are held until taken.
- `abort` is used only on a beat the bench means to end.

The stimulus keeps inside these limits in three ways. Random addresses are masked to the size alignment and sizes are drawn from 0..4. Commands are driven only in IDLE or on the cycle the final beat is accepted. Aborts are placed only on beat cycles with `bus_ready` forced high. `bus_ready` and `stall` are otherwise random, so holds, BUSY runs and stalls on final beats all occur.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    localparam logic [2:0] BT_SINGLE = 3'd0;
    localparam logic [2:0] BT_INCR   = 3'd1;
    localparam logic [2:0] BT_WRAP4  = 3'd2;
    localparam logic [2:0] BT_INCR4  = 3'd3;
    localparam logic [2:0] BT_WRAP8  = 3'd4;
    localparam logic [2:0] BT_INCR8  = 3'd5;
    localparam logic [2:0] BT_WRAP16 = 3'd6;
    localparam logic [2:0] BT_INCR16 = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BEAT = 2'd1,
        ST_BUSY = 2'd2
    } seq_state_e;

    // True for the three wrapping burst codes.
    function automatic logic burst_wraps(input logic [2:0] b);
        return (b == BT_WRAP4) || (b == BT_WRAP8) || (b == BT_WRAP16);
    endfunction

    // log2 of the beat count of a fixed-length burst; 0 for single and open-ended.
    function automatic logic [2:0] burst_len_log(input logic [2:0] b);
        logic [2:0] r;
        unique case (b)
            BT_WRAP4,  BT_INCR4:  r = 3'd2;
            BT_WRAP8,  BT_INCR8:  r = 3'd3;
            BT_WRAP16, BT_INCR16: r = 3'd4;
            default:              r = 3'd0;
        endcase
        return r;
    endfunction

    // Number of beats that follow the first one (0 for single and open-ended).
    function automatic logic [4:0] beats_after_first(input logic [2:0] b);
        logic [4:0] r;
        if ((b == BT_SINGLE) || (b == BT_INCR)) begin
            r = 5'd0;
        end else begin
            r = (5'd1 << burst_len_log(b)) - 5'd1;
        end
        return r;
    endfunction

endpackage

// File: rtl/bseq_next_addr.sv
module bseq_next_addr
    import bseq_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int MAX_SIZE = 4
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [2:0]        size_code,
    input  logic [2:0]        burst_code,
    output logic [ADDR_W-1:0] next_addr
);

    localparam int SZ_W = $clog2(MAX_SIZE + 1);

    logic [ADDR_W-1:0] step_cand [MAX_SIZE+1];
    logic [SZ_W-1:0]   sz_idx;
    logic [ADDR_W-1:0] stepped;
    logic [ADDR_W-1:0] span_mask;
    logic [3:0]        span_log;

    // One adder per legal size code; the size picks one of them.
    generate
        for (genvar s = 0; s <= MAX_SIZE; s++) begin : g_step
            assign step_cand[s] = cur_addr + (ADDR_W'(1) << s);
        end
    endgenerate

    always_comb begin
        sz_idx    = (size_code > 3'(MAX_SIZE)) ? SZ_W'(MAX_SIZE) : SZ_W'(size_code);
        stepped   = step_cand[sz_idx];
        span_log  = 4'(burst_len_log(burst_code)) + 4'(sz_idx);
        span_mask = (ADDR_W'(1) << span_log) - ADDR_W'(1);
        if (burst_wraps(burst_code)) begin
            next_addr = (cur_addr & ~span_mask) | (stepped & span_mask);
        end else begin
            next_addr = stepped;
        end
    end

endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
    parameter  int MAX_BEATS = 16,
    localparam int CNT_W     = $clog2(MAX_BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_rem,
    input  logic             load_open,
    input  logic             advance,
    output logic             last
);

    logic [CNT_W-1:0] rem_q;
    logic             open_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            open_q <= 1'b0;
        end else if (load) begin
            rem_q  <= load_rem;
            open_q <= load_open;
        end else if (advance && (rem_q != '0)) begin
            rem_q  <= rem_q - CNT_W'(1);
        end
    end

    // An open-ended burst never reaches its final beat on its own.
    assign last = !open_q && (rem_q == '0);

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_SIZE  = 4,
    parameter int MAX_BEATS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [2:0]        cmd_size,
    input  logic [2:0]        cmd_burst,
    input  logic              cmd_write,
    input  logic              stall,
    input  logic              abort,
    input  logic              bus_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_trans,
    output logic [2:0]        bus_size,
    output logic [2:0]        bus_burst,
    output logic              bus_write
);

    localparam int CNT_W = $clog2(MAX_BEATS);

    seq_state_e        state, nxt;
    logic              take;
    logic              last;
    logic              advance;
    logic [ADDR_W-1:0] step_addr;

    bseq_next_addr #(
        .ADDR_W   (ADDR_W),
        .MAX_SIZE (MAX_SIZE)
    ) u_next (
        .cur_addr   (bus_addr),
        .size_code  (bus_size),
        .burst_code (bus_burst),
        .next_addr  (step_addr)
    );

    // A new command fits when idle, on the final beat, or when the burst is cut.
    assign cmd_ready = bus_ready &&
                       ((state == ST_IDLE) || ((state == ST_BEAT) && last) || abort);
    assign take      = cmd_valid && cmd_ready;

    // The counter moves only when a SEQ beat is entered.
    assign advance = bus_ready && !take && !abort &&
                     (((state == ST_BEAT) && !last && !stall) ||
                      ((state == ST_BUSY) && !stall));

    bseq_beat_ctr #(
        .MAX_BEATS (MAX_BEATS)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take),
        .load_rem  (CNT_W'(beats_after_first(cmd_burst))),
        .load_open (cmd_burst == BT_INCR),
        .advance   (advance),
        .last      (last)
    );

    always_comb begin
        nxt = state;
        if (bus_ready) begin
            if (take) begin
                nxt = ST_BEAT;
            end else begin
                unique case (state)
                    ST_IDLE: nxt = ST_IDLE;
                    ST_BEAT: begin
                        if (abort || last) begin
                            nxt = ST_IDLE;
                        end else if (stall) begin
                            nxt = ST_BUSY;
                        end else begin
                            nxt = ST_BEAT;
                        end
                    end
                    ST_BUSY: begin
                        if (abort) begin
                            nxt = ST_IDLE;
                        end else if (stall) begin
                            nxt = ST_BUSY;
                        end else begin
                            nxt = ST_BEAT;
                        end
                    end
                    default: nxt = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_addr  <= '0;
            bus_trans <= TR_IDLE;
            bus_size  <= 3'd0;
            bus_burst <= BT_SINGLE;
            bus_write <= 1'b0;
        end else if (bus_ready) begin
            if (take) begin
                bus_addr  <= cmd_addr;
                bus_trans <= TR_NONSEQ;
                bus_size  <= cmd_size;
                bus_burst <= cmd_burst;
                bus_write <= cmd_write;
            end else begin
                unique case (nxt)
                    ST_IDLE: bus_trans <= TR_IDLE;
                    ST_BUSY: begin
                        bus_trans <= TR_BUSY;
                        if (state == ST_BEAT) begin
                            bus_addr <= step_addr;
                        end
                    end
                    ST_BEAT: begin
                        bus_trans <= TR_SEQ;
                        if (state == ST_BEAT) begin
                            bus_addr <= step_addr;
                        end
                    end
                    default: bus_trans <= TR_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/bseq_checker.sv
module bseq_checker
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              stall,
    input logic              abort,
    input logic              bus_ready,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_trans,
    input logic [2:0]        bus_size,
    input logic [2:0]        bus_burst
);

    function automatic logic [ADDR_W-1:0] wrap_mask(input logic [2:0] sz, input logic [2:0] b);
        return (ADDR_W'(1) << (4'(burst_len_log(b)) + 4'(sz))) - ADDR_W'(1);
    endfunction

    logic beat_now;
    assign beat_now = (bus_trans == TR_NONSEQ) || (bus_trans == TR_SEQ);

    assert_idle_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_trans == TR_IDLE) |-> (cmd_ready == bus_ready));

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=>
            ((bus_trans == TR_NONSEQ) && (bus_addr == $past(cmd_addr))));

    assert_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_burst == BT_SINGLE) |-> ((bus_trans == TR_IDLE) || (bus_trans == TR_NONSEQ)));

    assert_incr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && beat_now && !burst_wraps(bus_burst)) |=>
            (!((bus_trans == TR_SEQ) || (bus_trans == TR_BUSY)) ||
             (bus_addr == $past(bus_addr) + (ADDR_W'(1) << $past(bus_size)))));

    assert_wrap_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && beat_now && burst_wraps(bus_burst)) |=>
            (!((bus_trans == TR_SEQ) || (bus_trans == TR_BUSY)) ||
             (((bus_addr ^ $past(bus_addr)) & ~wrap_mask(bus_size, bus_burst)) == '0)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |=> ($stable(bus_addr) && $stable(bus_trans) &&
                        $stable(bus_size) && $stable(bus_burst)));

    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && (bus_trans == TR_BUSY) && !abort) |=>
            ((bus_trans == ($past(stall) ? TR_BUSY : TR_SEQ)) && $stable(bus_addr)));

    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && abort && !cmd_valid && (bus_trans != TR_IDLE)) |=>
            (bus_trans == TR_IDLE));

endmodule

bind burst_addr_seq bseq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_addr  (cmd_addr),
    .stall     (stall),
    .abort     (abort),
    .bus_ready (bus_ready),
    .bus_addr  (bus_addr),
    .bus_trans (bus_trans),
    .bus_size  (bus_size),
    .bus_burst (bus_burst)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr = '0;
    logic [2:0]  cmd_size = '0;
    logic [2:0]  cmd_burst = '0;
    logic        cmd_write = 1'b0;
    logic        stall = 1'b0;
    logic        abort = 1'b0;
    logic        bus_ready = 1'b1;
    logic [31:0] bus_addr;
    logic [1:0]  bus_trans;
    logic [2:0]  bus_size;
    logic [2:0]  bus_burst;
    logic        bus_write;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_size(cmd_size), .cmd_burst(cmd_burst),
        .cmd_write(cmd_write), .stall(stall), .abort(abort), .bus_ready(bus_ready),
        .bus_addr(bus_addr), .bus_trans(bus_trans), .bus_size(bus_size),
        .bus_burst(bus_burst), .bus_write(bus_write)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int beats_of(input logic [2:0] bt);
        case (bt)
            3'd2, 3'd3: return 4;
            3'd4, 3'd5: return 8;
            3'd6, 3'd7: return 16;
            default:    return 1;
        endcase
    endfunction

    function automatic bit wraps(input logic [2:0] bt);
        return (bt == 3'd2) || (bt == 3'd4) || (bt == 3'd6);
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] a, input logic [2:0] sz,
                                             input logic [2:0] bt, input int k);
        logic [31:0] bytes;
        logic [31:0] blk;
        bytes = 32'd1 << sz;
        if (wraps(bt)) begin
            blk = 32'(beats_of(bt)) * bytes;
            return (a & ~(blk - 1)) | ((a + 32'(k) * bytes) & (blk - 1));
        end
        return a + 32'(k) * bytes;
    endfunction

    // Offer a command from IDLE (R1: cmd_ready must follow bus_ready there).
    task automatic issue(input logic [31:0] a, input logic [2:0] sz,
                         input logic [2:0] bt, input logic wr);
        @(negedge clk);
        cmd_addr = a; cmd_size = sz; cmd_burst = bt; cmd_write = wr;
        cmd_valid = 1'b1; bus_ready = 1'b1; stall = 1'b0; abort = 1'b0;
        #1;
        check("R1", "trans before command", 32'(bus_trans), 32'd0);
        check("R1", "cmd_ready in idle", 32'(cmd_ready), 32'd1);
    endtask

    // Follow one burst cycle by cycle with random ready/stall.
    task automatic play(input logic [31:0] a, input logic [2:0] sz, input logic [2:0] bt,
                        input logic wr, input int len, input int abort_at, input bit chained_in,
                        input bit chain_out, input logic [31:0] na, input logic [2:0] nsz,
                        input logic [2:0] nbt, input logic nwr);
        int  k = 0;
        bit  busy = 0;
        bit  done = 0;
        bit  prev_rdy = 1;
        int  endb;
        endb = (abort_at >= 0) ? abort_at : len - 1;
        while (!done) begin
            string tt;
            string ta;
            logic [1:0] et;
            bit rdy;
            bit st;
            bit ab;
            @(negedge clk);
            et = busy ? 2'b01 : ((k == 0) ? 2'b10 : 2'b11);
            tt = busy ? "R8" : ((k == 0) ? (chained_in ? "R10" : "R2") : "R6");
            ta = busy ? "R8" : ((k == 0) ? (chained_in ? "R10" : "R2") : (wraps(bt) ? "R5" : "R4"));
            if (!prev_rdy) begin
                tt = "R7";
                ta = "R7";
            end
            check(tt, $sformatf("trans beat %0d", k), 32'(bus_trans), 32'(et));
            check(ta, $sformatf("addr beat %0d", k), bus_addr, exp_addr(a, sz, bt, k));
            check((k == 0) ? "R2" : "R7", "size/burst/write",
                  {25'd0, bus_size, bus_burst, bus_write}, {25'd0, sz, bt, wr});
            rdy = ($urandom % 4) != 0;
            st  = ($urandom % 4) == 0;
            ab  = !busy && (k == abort_at);
            if (ab) rdy = 1;
            cmd_valid = chain_out && !busy && (k == endb) && rdy;
            if (cmd_valid) begin
                cmd_addr = na; cmd_size = nsz; cmd_burst = nbt; cmd_write = nwr;
            end
            bus_ready = rdy; stall = st; abort = ab;
            if (rdy) begin
                if (busy) begin
                    if (!st) busy = 0;
                end else if (k == endb) begin
                    done = 1;
                end else if (st) begin
                    busy = 1;
                    k++;
                end else begin
                    k++;
                end
            end
            prev_rdy = rdy;
        end
        if (!chain_out) begin
            @(negedge clk);
            check((bt == 3'd1 || (abort_at >= 0 && abort_at < len - 1)) ? "R9" : "R3",
                  "trans after burst", 32'(bus_trans), 32'd0);
            cmd_valid = 1'b0; abort = 1'b0; stall = 1'b0; bus_ready = 1'b1;
        end
    endtask

    task automatic gen(output logic [31:0] a, output logic [2:0] sz, output logic [2:0] bt,
                       output logic wr, output int len, output int abort_at);
        sz = 3'($urandom % 5);
        bt = 3'($urandom % 8);
        wr = 1'($urandom % 2);
        a  = $urandom & ~((32'd1 << sz) - 1);
        if (bt == 3'd1) begin
            len = 1 + int'($urandom % 12);
            abort_at = len - 1;
        end else begin
            len = beats_of(bt);
            abort_at = (($urandom % 8) == 0) ? int'($urandom % len) : -1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] ca;
        logic [2:0]  csz;
        logic [2:0]  cbt;
        logic        cwr;
        int          clen;
        int          cab;
        bit          chained;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (3) @(negedge clk);
        bus_ready = 1'b0;
        #1;
        check("R1", "trans in reset", 32'(bus_trans), 32'd0);
        check("R1", "cmd_ready low with bus_ready low", 32'(cmd_ready), 32'd0);
        bus_ready = 1'b1;
        #1;
        check("R1", "cmd_ready high with bus_ready high", 32'(cmd_ready), 32'd1);
        @(negedge clk);
        rst_n = 1'b1;

        // R5: 4-beat wrap, 4-byte beats, block 0x1010..0x101F
        issue(32'h1010, 3'd2, 3'd2, 1'b1);
        play(32'h1010, 3'd2, 3'd2, 1'b1, 4, -1, 0, 0, 0, 0, 0, 0);
        // R5: 8-beat wrap, 2-byte beats, start mid block
        issue(32'h2028, 3'd1, 3'd4, 1'b0);
        play(32'h2028, 3'd1, 3'd4, 1'b0, 8, -1, 0, 0, 0, 0, 0, 0);
        // R5: 16-beat wrap of 16-byte beats, start near block top
        issue(32'h0000_00F0, 3'd4, 3'd6, 1'b0);
        play(32'h0000_00F0, 3'd4, 3'd6, 1'b0, 16, -1, 0, 0, 0, 0, 0, 0);
        // R4/R10: rollover at the top of the address space, chained to a single then INCR16
        issue(32'hFFFF_FFF8, 3'd2, 3'd3, 1'b1);
        play(32'hFFFF_FFF8, 3'd2, 3'd3, 1'b1, 4, -1, 0, 1, 32'h33, 3'd0, 3'd0, 1'b0);
        play(32'h33, 3'd0, 3'd0, 1'b0, 1, -1, 1, 1, 32'h100, 3'd0, 3'd7, 1'b1);
        play(32'h100, 3'd0, 3'd7, 1'b1, 16, -1, 1, 0, 0, 0, 0, 0);
        // R9: open-ended burst ended by abort after six beats
        issue(32'h4000, 3'd3, 3'd1, 1'b0);
        play(32'h4000, 3'd3, 3'd1, 1'b0, 6, 5, 0, 0, 0, 0, 0, 0);
        // R9: wrap16 cut at beat 5
        issue(32'h0000_0340, 3'd2, 3'd6, 1'b1);
        play(32'h0000_0340, 3'd2, 3'd6, 1'b1, 16, 5, 0, 0, 0, 0, 0, 0);

        // Random bursts with random chaining
        gen(ca, csz, cbt, cwr, clen, cab);
        chained = 0;
        for (int i = 0; i < 80; i++) begin
            logic [31:0] na;
            logic [2:0]  nsz;
            logic [2:0]  nbt;
            logic        nwr;
            int          nlen;
            int          nab;
            bit          co;
            gen(na, nsz, nbt, nwr, nlen, nab);
            co = (i < 79) && (($urandom % 2) == 1);
            if (!chained) issue(ca, csz, cbt, cwr);
            play(ca, csz, cbt, cwr, clen, cab, chained, co, na, nsz, nbt, nwr);
            chained = co;
            ca = na; csz = nsz; cbt = nbt; cwr = nwr; clen = nlen; cab = nab;
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule